// File: doc/BRIEF.md
# ECC Error Reporting Controller

This block gathers non-correctable ECC error events coming from two memory sources, an on-chip RAM and a flash array. Each source has an enable bit in a small configuration register. An error from an enabled source sets that source's status flag and clears the other source's flag, so the status always names the most recent enabled event. The same event also latches the faulting access (address, access attributes, data word and the number of the requesting bus master) into a capture set that belongs to that source. An interrupt is raised while any enabled source has its flag set.

Software reaches the block over a byte-wide register bus with byte addresses. Reads are combinational. Writes take effect at the next clock edge. Status flags are cleared by writing a one to them. The capture sets can only be read. Software uses them after the interrupt to find the failing location and the master that made the access.

Top module: `ecc_err_report`

## Requirements
- R1: After reset, the configuration byte (0x43) and the status byte (0x47) read 0x00, every capture byte reads 0x00 and `irq_o` is low.
- R2: The configuration byte at address 0x43 is readable and writable. Bit 1 (value 0x02) enables RAM reporting and bit 0 (value 0x01) enables flash reporting. Bits 7:2 always read 0, whatever was written. Addresses that are not mapped read 0x00.
- R3: `irq_o` is high exactly when (RAM enable and RAM flag) or (flash enable and flash flag) holds. Clearing an enable bit masks the interrupt but leaves the flag readable.
- R4: The status byte at 0x47 holds the RAM flag in bit 1 and the flash flag in bit 0. An enabled RAM error makes it read 0x02 after the next edge, and an enabled flash error makes it read 0x01.
- R5: Writing the status byte clears each flag whose written bit is 1. Written bits that are 0 leave their flag unchanged.
- R6: An error from a source whose enable bit is clear changes neither the status flags nor that source's capture set.
- R7: When RAM and flash errors arrive in the same cycle and both are enabled, the status reads 0x02 and both capture sets are loaded.
- R8: The RAM capture set starts at 0x50 and the flash capture set starts at 0x60. Within a set, offsets +0 to +3 hold the address (least significant byte first), +4 holds the master number, +5 holds the attributes, and +8 to +B hold the data word (least significant byte first). Each set holds the values its source presented during the enabled error cycle.
- R9: A capture set keeps its contents until the next enabled error of its own source. Bus writes to capture addresses have no effect.
- R10: When an enabled error and a status write arrive in the same cycle, the status takes the value set by the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ram_err_i | input | 1 | RAM non-correctable error event |
| ram_addr_i | input | AW | RAM faulting address |
| ram_attr_i | input | TW | RAM access attributes |
| ram_data_i | input | DW | RAM faulting data |
| ram_mid_i | input | MW | RAM requesting master number |
| flash_err_i | input | 1 | Flash non-correctable error event |
| flash_addr_i | input | AW | Flash faulting address |
| flash_attr_i | input | TW | Flash access attributes |
| flash_data_i | input | DW | Flash faulting data |
| flash_mid_i | input | MW | Flash requesting master number |
| irq_o | output | 1 | ECC error interrupt request |

## Verification
The assertions are checked on every cycle. They cover how an enabled event of each source sets the status, RAM priority when both sources fire together, the loading of the captured address and its holding when no enabled event occurs, the status staying unchanged when it has no event and no write, and the interrupt never rising without a flag. Other behaviour shows only through the bench's scenarios read back over the bus. This includes the byte layout of the capture sets, the read-zero reserved bits, masking by the enable bits, write-one-to-clear, bus writes to capture addresses being ignored, and an event winning over a clear in the same cycle.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int unsigned NSRC    = 2;
  localparam int unsigned SRC_RAM = 1;
  localparam int unsigned SRC_FLS = 0;

  localparam logic [7:0] OFF_CFG  = 8'h43;
  localparam logic [7:0] OFF_STAT = 8'h47;
  localparam logic [7:0] OFF_RAM  = 8'h50;
  localparam logic [7:0] OFF_FLS  = 8'h60;
  localparam logic [7:0] CAP_SPAN = 8'h10;

  localparam logic [3:0] FLD_MID  = 4'h4;
  localparam logic [3:0] FLD_ATTR = 4'h5;
  localparam logic [3:0] FLD_DATA = 4'h8;

  function automatic logic [7:0] cap_base(input int unsigned src);
    return (src == SRC_RAM) ? OFF_RAM : OFF_FLS;
  endfunction
endpackage

// File: rtl/ecc_rpt_ctrl.sv
module ecc_rpt_ctrl
  import ecc_rpt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            stat_we_i,
  input  logic [7:0]      wdata_i,
  input  logic [NSRC-1:0] err_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] take_o,
  output logic            irq_o
);
  logic [NSRC-1:0] cfg_q, stat_q, take;

  assign take = err_i & cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= wdata_i[NSRC-1:0];
  end

  // latest enabled event wins; RAM has priority; event beats a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (|take) begin
      stat_q <= '0;
      if (take[SRC_RAM]) stat_q[SRC_RAM] <= 1'b1;
      else               stat_q[SRC_FLS] <= 1'b1;
    end else if (stat_we_i) begin
      stat_q <= stat_q & ~wdata_i[NSRC-1:0];
    end
  end

  assign en_o   = cfg_q;
  assign stat_o = stat_q;
  assign take_o = take;
  assign irq_o  = |(cfg_q & stat_q);
endmodule

// File: rtl/ecc_rpt_capture.sv
module ecc_rpt_capture #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 8,
  parameter int unsigned MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] attr_i,
  input  logic [DW-1:0] data_i,
  input  logic [MW-1:0] mid_i,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] attr_o,
  output logic [DW-1:0] data_o,
  output logic [MW-1:0] mid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      attr_o <= '0;
      data_o <= '0;
      mid_o  <= '0;
    end else if (take_i) begin
      addr_o <= addr_i;
      attr_o <= attr_i;
      data_o <= data_i;
      mid_o  <= mid_i;
    end
  end
endmodule

// File: rtl/ecc_rpt_rdmux.sv
module ecc_rpt_rdmux
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 8,
  parameter int unsigned MW = 4
) (
  input  logic [7:0]                 addr_i,
  input  logic [NSRC-1:0]            en_i,
  input  logic [NSRC-1:0]            stat_i,
  input  logic [NSRC-1:0][AW-1:0]    cap_addr_i,
  input  logic [NSRC-1:0][TW-1:0]    cap_attr_i,
  input  logic [NSRC-1:0][DW-1:0]    cap_data_i,
  input  logic [NSRC-1:0][MW-1:0]    cap_mid_i,
  output logic [7:0]                 rdata_o
);
  localparam int unsigned ABYTES = (AW + 7) / 8;
  localparam int unsigned DBYTES = (DW + 7) / 8;

  logic [8*ABYTES-1:0] a_ext;
  logic [8*DBYTES-1:0] d_ext;
  logic [7:0]          m_ext, t_ext, diff;
  logic [3:0]          off;

  always_comb begin
    rdata_o = '0;
    a_ext   = '0;
    d_ext   = '0;
    m_ext   = '0;
    t_ext   = '0;
    diff    = '0;
    off     = '0;
    if (addr_i == OFF_CFG)  rdata_o[NSRC-1:0] = en_i;
    if (addr_i == OFF_STAT) rdata_o[NSRC-1:0] = stat_i;
    for (int s = 0; s < NSRC; s++) begin
      diff = addr_i - cap_base(s);
      if (addr_i >= cap_base(s) && diff < CAP_SPAN) begin
        off            = diff[3:0];
        a_ext          = '0;
        d_ext          = '0;
        m_ext          = '0;
        t_ext          = '0;
        a_ext[AW-1:0]  = cap_addr_i[s];
        d_ext[DW-1:0]  = cap_data_i[s];
        m_ext[MW-1:0]  = cap_mid_i[s];
        t_ext[TW-1:0]  = cap_attr_i[s];
        if (32'(off) < ABYTES)                         rdata_o = a_ext[8*off +: 8];
        else if (off == FLD_MID)                       rdata_o = m_ext;
        else if (off == FLD_ATTR)                      rdata_o = t_ext;
        else if (off >= FLD_DATA && 32'(off - FLD_DATA) < DBYTES)
                                                       rdata_o = d_ext[8*(off - FLD_DATA) +: 8];
      end
    end
  end
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 8,
  parameter int unsigned MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    reg_addr_i,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          ram_err_i,
  input  logic [AW-1:0] ram_addr_i,
  input  logic [TW-1:0] ram_attr_i,
  input  logic [DW-1:0] ram_data_i,
  input  logic [MW-1:0] ram_mid_i,
  input  logic          flash_err_i,
  input  logic [AW-1:0] flash_addr_i,
  input  logic [TW-1:0] flash_attr_i,
  input  logic [DW-1:0] flash_data_i,
  input  logic [MW-1:0] flash_mid_i,
  output logic          irq_o
);
  logic [NSRC-1:0]         err, cfg_q, stat_q, take;
  logic [NSRC-1:0][AW-1:0] src_addr, cap_addr;
  logic [NSRC-1:0][TW-1:0] src_attr, cap_attr;
  logic [NSRC-1:0][DW-1:0] src_data, cap_data;
  logic [NSRC-1:0][MW-1:0] src_mid,  cap_mid;
  logic                    cfg_we, stat_we;

  assign err[SRC_RAM]      = ram_err_i;
  assign err[SRC_FLS]      = flash_err_i;
  assign src_addr[SRC_RAM] = ram_addr_i;
  assign src_addr[SRC_FLS] = flash_addr_i;
  assign src_attr[SRC_RAM] = ram_attr_i;
  assign src_attr[SRC_FLS] = flash_attr_i;
  assign src_data[SRC_RAM] = ram_data_i;
  assign src_data[SRC_FLS] = flash_data_i;
  assign src_mid[SRC_RAM]  = ram_mid_i;
  assign src_mid[SRC_FLS]  = flash_mid_i;

  assign cfg_we  = reg_we_i && (reg_addr_i == OFF_CFG);
  assign stat_we = reg_we_i && (reg_addr_i == OFF_STAT);

  ecc_rpt_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we),
    .stat_we_i(stat_we),
    .wdata_i  (reg_wdata_i),
    .err_i    (err),
    .en_o     (cfg_q),
    .stat_o   (stat_q),
    .take_o   (take),
    .irq_o    (irq_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_cap
    ecc_rpt_capture #(.AW(AW), .DW(DW), .TW(TW), .MW(MW)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(take[g]),
      .addr_i(src_addr[g]),
      .attr_i(src_attr[g]),
      .data_i(src_data[g]),
      .mid_i (src_mid[g]),
      .addr_o(cap_addr[g]),
      .attr_o(cap_attr[g]),
      .data_o(cap_data[g]),
      .mid_o (cap_mid[g])
    );
  end

  ecc_rpt_rdmux #(.AW(AW), .DW(DW), .TW(TW), .MW(MW)) u_rd (
    .addr_i    (reg_addr_i),
    .en_i      (cfg_q),
    .stat_i    (stat_q),
    .cap_addr_i(cap_addr),
    .cap_attr_i(cap_attr),
    .cap_data_i(cap_data),
    .cap_mid_i (cap_mid),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/ecc_rpt_checker.sv
module ecc_rpt_checker
  import ecc_rpt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ram_err_i,
  input logic                    flash_err_i,
  input logic [AW-1:0]           ram_addr_i,
  input logic [AW-1:0]           flash_addr_i,
  input logic                    reg_we_i,
  input logic [7:0]              reg_addr_i,
  input logic                    irq_o,
  input logic [NSRC-1:0]         en_i,
  input logic [NSRC-1:0]         stat_i,
  input logic [NSRC-1:0][AW-1:0] cap_addr_i
);
  logic ram_ev, fls_ev, stat_wr;
  assign ram_ev  = ram_err_i && en_i[SRC_RAM];
  assign fls_ev  = flash_err_i && en_i[SRC_FLS];
  assign stat_wr = reg_we_i && (reg_addr_i == OFF_STAT);

  a_r4_ram_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_ev |=> (stat_i == 2'b10));
  a_r4_flash_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fls_ev && !ram_ev) |=> (stat_i == 2'b01));
  a_r7_ram_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_ev && fls_ev) |=> (stat_i[SRC_RAM] && !stat_i[SRC_FLS]));
  a_r8_ram_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_ev |=> (cap_addr_i[SRC_RAM] == $past(ram_addr_i)));
  a_r8_flash_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fls_ev |=> (cap_addr_i[SRC_FLS] == $past(flash_addr_i)));
  a_r9_ram_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_ev |=> $stable(cap_addr_i[SRC_RAM]));
  a_r9_flash_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fls_ev |=> $stable(cap_addr_i[SRC_FLS]));
  a_r6_stat_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ev && !fls_ev && !stat_wr) |=> $stable(stat_i));
  a_r3_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_i != '0));
endmodule

bind ecc_err_report ecc_rpt_checker #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ram_err_i   (ram_err_i),
  .flash_err_i (flash_err_i),
  .ram_addr_i  (ram_addr_i),
  .flash_addr_i(flash_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .irq_o       (irq_o),
  .en_i        (cfg_q),
  .stat_i      (stat_q),
  .cap_addr_i  (cap_addr)
);

// File: tb/ecc_err_report_test.sv
module ecc_err_report_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        ram_err_i = 1'b0, flash_err_i = 1'b0;
  logic [31:0] ram_addr_i = '0, flash_addr_i = '0;
  logic [7:0]  ram_attr_i = '0, flash_attr_i = '0;
  logic [31:0] ram_data_i = '0, flash_data_i = '0;
  logic [3:0]  ram_mid_i = '0, flash_mid_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ecc_err_report uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_cap(input logic [7:0] base, output logic [31:0] a,
                        output logic [7:0] m, output logic [7:0] t, output logic [31:0] d);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin reg_rd(base + 8'(i), b); a[8*i +: 8] = b; end
    reg_rd(base + 8'h4, m);
    reg_rd(base + 8'h5, t);
    for (int i = 0; i < 4; i++) begin reg_rd(base + 8'h8 + 8'(i), b); d[8*i +: 8] = b; end
  endtask

  task automatic pulse(input logic r, input logic f);
    @(negedge clk_i);
    ram_err_i = r; flash_err_i = f;
    @(negedge clk_i);
    ram_err_i = 1'b0; flash_err_i = 1'b0;
  endtask

  task automatic chk_cap(input string tag, input logic [7:0] base, input logic [31:0] ea,
                         input logic [7:0] em, input logic [7:0] et, input logic [31:0] ed);
    logic [31:0] a, d;
    logic [7:0] m, t;
    rd_cap(base, a, m, t, d);
    chk({tag, " addr"}, a, ea);
    chk({tag, " mid"}, 32'(m), 32'(em));
    chk({tag, " attr"}, 32'(t), 32'(et));
    chk({tag, " data"}, d, ed);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    reg_rd(8'h43, v); chk("R1 cfg", 32'(v), 0);
    reg_rd(8'h47, v); chk("R1 stat", 32'(v), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk_cap("R1 ram cap", 8'h50, 0, 0, 0, 0);
  endtask

  task automatic t_cfg;
    logic [7:0] v;
    reg_wr(8'h43, 8'hFF); reg_rd(8'h43, v); chk("R2 reserved zero", 32'(v), 32'h03);
    reg_wr(8'h43, 8'h02); reg_rd(8'h43, v); chk("R2 cfg rw", 32'(v), 32'h02);
    reg_rd(8'h44, v); chk("R2 unmapped", 32'(v), 0);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    reg_wr(8'h43, 8'h00);
    ram_addr_i = 32'hDEAD_0001; ram_mid_i = 4'h9; ram_attr_i = 8'h33; ram_data_i = 32'h1111_2222;
    pulse(1'b1, 1'b0);
    reg_rd(8'h47, v); chk("R6 stat after disabled ram", 32'(v), 0);
    chk("R6 irq", 32'(irq_o), 0);
    chk_cap("R6 ram cap", 8'h50, 0, 0, 0, 0);
    reg_wr(8'h43, 8'h02);
    flash_addr_i = 32'hBEEF_0002; flash_mid_i = 4'h5; flash_attr_i = 8'h44; flash_data_i = 32'h3333_4444;
    pulse(1'b0, 1'b1);
    reg_rd(8'h47, v); chk("R6 stat after disabled flash", 32'(v), 0);
    chk_cap("R6 flash cap", 8'h60, 0, 0, 0, 0);
  endtask

  task automatic t_ram_event;
    logic [7:0] v;
    reg_wr(8'h43, 8'h03);
    ram_addr_i = 32'h4000_1230; ram_mid_i = 4'h2; ram_attr_i = 8'hA5; ram_data_i = 32'hCAFE_F00D;
    pulse(1'b1, 1'b0);
    reg_rd(8'h47, v); chk("R4 ram stat", 32'(v), 32'h02);
    chk("R3 irq ram", 32'(irq_o), 1);
    ram_addr_i = 32'h0; ram_data_i = 32'h0;
    chk_cap("R8 ram cap", 8'h50, 32'h4000_1230, 8'h02, 8'hA5, 32'hCAFE_F00D);
  endtask

  task automatic t_flash_event;
    logic [7:0] v;
    flash_addr_i = 32'h0010_0400; flash_mid_i = 4'hC; flash_attr_i = 8'h5A; flash_data_i = 32'h0BAD_BEEF;
    pulse(1'b0, 1'b1);
    reg_rd(8'h47, v); chk("R4 flash stat", 32'(v), 32'h01);
    chk_cap("R8 flash cap", 8'h60, 32'h0010_0400, 8'h0C, 8'h5A, 32'h0BAD_BEEF);
    chk_cap("R9 ram cap held", 8'h50, 32'h4000_1230, 8'h02, 8'hA5, 32'hCAFE_F00D);
  endtask

  task automatic t_irq_mask;
    logic [7:0] v;
    reg_wr(8'h43, 8'h02);
    #1 chk("R3 irq masked", 32'(irq_o), 0);
    reg_rd(8'h47, v); chk("R3 flag kept", 32'(v), 32'h01);
    reg_wr(8'h43, 8'h03);
    #1 chk("R3 irq unmasked", 32'(irq_o), 1);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    reg_wr(8'h47, 8'h02);
    reg_rd(8'h47, v); chk("R5 write other bit", 32'(v), 32'h01);
    reg_wr(8'h47, 8'h00);
    reg_rd(8'h47, v); chk("R5 write zero", 32'(v), 32'h01);
    reg_wr(8'h47, 8'h01);
    reg_rd(8'h47, v); chk("R5 cleared", 32'(v), 0);
    chk("R5 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_cap_ro;
    for (int i = 0; i < 12; i++) reg_wr(8'h50 + 8'(i), 8'hAA);
    for (int i = 0; i < 12; i++) reg_wr(8'h60 + 8'(i), 8'h55);
    chk_cap("R9 ram cap write", 8'h50, 32'h4000_1230, 8'h02, 8'hA5, 32'hCAFE_F00D);
    chk_cap("R9 flash cap write", 8'h60, 32'h0010_0400, 8'h0C, 8'h5A, 32'h0BAD_BEEF);
  endtask

  task automatic t_both;
    logic [7:0] v;
    ram_addr_i = 32'h1234_5678; ram_mid_i = 4'h7; ram_attr_i = 8'h11; ram_data_i = 32'h8765_4321;
    flash_addr_i = 32'h9ABC_DEF0; flash_mid_i = 4'h3; flash_attr_i = 8'h22; flash_data_i = 32'h0F0F_F0F0;
    pulse(1'b1, 1'b1);
    reg_rd(8'h47, v); chk("R7 ram priority", 32'(v), 32'h02);
    chk_cap("R7 ram cap", 8'h50, 32'h1234_5678, 8'h07, 8'h11, 32'h8765_4321);
    chk_cap("R7 flash cap", 8'h60, 32'h9ABC_DEF0, 8'h03, 8'h22, 32'h0F0F_F0F0);
  endtask

  task automatic t_race;
    logic [7:0] v;
    @(negedge clk_i);
    flash_err_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 8'h47; reg_wdata_i = 8'h03;
    @(negedge clk_i);
    flash_err_i = 1'b0; reg_we_i = 1'b0;
    reg_rd(8'h47, v); chk("R10 event beats clear", 32'(v), 32'h01);
    chk("R10 irq", 32'(irq_o), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cfg();
    t_disabled();
    t_ram_event();
    t_flash_event();
    t_irq_mask();
    t_w1c();
    t_cap_ro();
    t_both();
    t_race();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule